// File: doc/BRIEF.md
# Auto-Incrementing Indirect SRAM Port

This block gives a byte-wide CPU bus indirect access to a 4 KB internal SRAM. The CPU first sets a 24-bit pointer one byte at a time through three pointer offsets. It then moves data through one data offset. Every data read or data write uses the byte at the low 12 pointer bits and then advances the whole pointer by one. A block of bytes can therefore be streamed with repeated accesses to a single address.

The port is live only while the `port_en` input is high. That input is one bit of a control register that lives outside this block. Decoding looks at address bits [13:0] only, so the four offsets appear again in every 16 KB window of the 64 KB bus. A short list of fixed register addresses that belong to the surrounding logic is excluded from decoding.

The bus has no back-pressure and no valid/ready handshake. A write is accepted in the cycle in which its strobe is first seen high. Read data is registered and sits on `bus_rdata` from the cycle after the read strobe is first seen high. It holds that value until the next accepted data read. A strobe held high for several cycles counts as one access. If both strobes rise together, the write is taken and the read is dropped.

Top module: `sram_port`

## Requirements
- R1: After reset the pointer is 0 and `bus_rdata` is 0x00. A data access made before any pointer load therefore uses SRAM byte 0.
- R2: Offsets are decoded from `bus_addr[13:0]` only. Offset 0x3FFA is the high pointer byte, 0x3FFB the middle byte, 0x3FFC the low byte and 0x3FFD data. They act the same at 0x3FFx, 0x7FFx, 0xBFFx and 0xFFFx.
- R3: A write to a pointer offset replaces only that byte: bits [23:16], [15:8] or [7:0]. The other two bytes keep their values.
- R4: A write to offset 0x3FFD stores `bus_wdata` at SRAM[pointer[11:0]] and then adds one to the pointer.
- R5: A read at offset 0x3FFD puts SRAM[pointer[11:0]] on `bus_rdata` in the cycle after the strobe is first seen high, and then adds one to the pointer.
- R6: Only pointer[11:0] selects the SRAM byte. Pointer bits [23:12] never change which byte is used, so a pointer of 0xAB0FFF followed by one increment moves from byte 0xFFF to byte 0x000.
- R7: An increment from 0xFFFFFF gives 0x000000.
- R8: While `port_en` is low, pointer loads, data writes and data reads are ignored. The pointer, the SRAM and `bus_rdata` all stay unchanged.
- R9: A read or write strobe held high for several cycles is one access and causes exactly one increment.
- R10: The fixed register addresses 0x6000, 0x6400, 0x7000, 0x7400 and 0x7FF9 are not decoded by the port. Any other offset outside 0x3FFA to 0x3FFD is ignored as well. Neither kind changes the pointer, the SRAM or `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port enable, taken from a control register bit |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, level |
| bus_wr | input | 1 | Write strobe, level |
| bus_rdata | output | 8 | Registered read data from the data offset |

## Verification
Data streams are written through one mirror of the data offset and read back through other mirrors. This shows that decoding does not depend on the address bits above bit 13. Pointer bytes are reloaded one at a time between the streams, and the read-back shows whether the other bytes were kept. Pointers placed at 0x000FFF, 0xAB0FFF and 0xFFFFFF separate wrapping at 12 bits from any use of the upper pointer bits. Disabled accesses, writes to the fixed register addresses and long-held strobes are each followed by a read that would land on a different byte if the pointer had moved.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  localparam int FIXED_N = 5;
  localparam logic [15:0] FIXED_REGS [FIXED_N] =
    '{16'h6000, 16'h6400, 16'h7000, 16'h7400, 16'h7FF9};

  function automatic logic is_fixed(input logic [15:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < FIXED_N; i++)
      if (a == FIXED_REGS[i]) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/sram_ptr.sv
module sram_ptr #(
  parameter int PW = 24,
  parameter int BW = 8,
  localparam int NB = PW / BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] ld,
  input  logic [BW-1:0] ld_data,
  input  logic          inc,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (inc) ptr <= ptr + 1'b1;
    else begin
      for (int b = 0; b < NB; b++)
        if (ld[b]) ptr[b*BW +: BW] <= ld_data;
    end
  end

  // R3: each byte lane loads alone and otherwise holds
  for (genvar g = 0; g < NB; g++) begin : g_lane
    p_lane_load_r3: assert property (@(posedge clk) disable iff (rst)
      (ld[g] && !inc) |=> ptr[g*BW +: BW] == $past(ld_data));
    p_lane_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!ld[g] && !inc) |=> $stable(ptr[g*BW +: BW]));
  end

  // R4 / R5: one access advances the full pointer by one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    inc |=> ptr == PW'($past(ptr) + 1'b1));

  // R7: top value rolls over to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && (&ptr)) |=> ptr == '0);
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (re) rd <= mem[addr];
  end

  // R5: read and write never fire together
  p_excl_r5: assert property (@(posedge clk) disable iff (rst) !(we && re));
endmodule

// File: rtl/sram_port.sv
module sram_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 24,
  parameter int RAM_AW = 12,
  parameter int DEC_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NB = PTR_W / DATA_W;
  localparam logic [DEC_W-1:0] DATA_OFF  = DEC_W'((1 << DEC_W) - 3);
  localparam logic [DEC_W-1:0] PORT_BASE = DEC_W'(DATA_OFF - NB);

  logic              wr_rise, rd_rise;
  logic              fixed_hit, wr_go, rd_go, data_sel;
  logic [DEC_W-1:0]  off;
  logic [NB-1:0]     ld;
  logic              ptr_inc;
  logic [PTR_W-1:0]  ptr;

  strobe_rise u_wr_edge (.clk(clk), .rst(rst), .lvl(bus_wr), .rise(wr_rise));
  strobe_rise u_rd_edge (.clk(clk), .rst(rst), .lvl(bus_rd), .rise(rd_rise));

  always_comb begin
    off       = bus_addr[DEC_W-1:0];
    fixed_hit = is_fixed(16'(bus_addr));
    data_sel  = (off == DATA_OFF);
    wr_go     = port_en && wr_rise && !fixed_hit;
    rd_go     = port_en && rd_rise && !wr_rise && data_sel;
    ptr_inc   = (wr_go && data_sel) || rd_go;
  end

  // Byte lane b is loaded from offset PORT_BASE + (NB-1-b): high byte first
  for (genvar b = 0; b < NB; b++) begin : g_ld
    assign ld[b] = wr_go && (off == DEC_W'(PORT_BASE + (NB - 1 - b)));
  end

  sram_ptr #(.PW(PTR_W), .BW(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .ld(ld), .ld_data(bus_wdata),
    .inc(ptr_inc), .ptr(ptr)
  );

  byte_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_go && data_sel), .re(rd_go),
    .addr(ptr[RAM_AW-1:0]), .wd(bus_wdata), .rd(bus_rdata)
  );

  // R8: a disabled port changes nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> ($stable(ptr) && $stable(bus_rdata)));

  // R9: a read strobe still high from the last cycle does not step again
  p_once_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && $past(bus_rd) && !bus_wr) |=> $stable(ptr));

  // R10: fixed register writes leave the pointer alone
  p_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && fixed_hit && !bus_rd) |=> $stable(ptr));

  // R2: only one pointer lane loads per write
  p_lane_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(ld));
endmodule

// File: tb/tb_sram_port.sv
`timescale 1ns/1ps
module tb_sram_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sram_port dut (
    .clk(clk), .rst(rst), .port_en(port_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        rd;
    logic [15:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h3FFA, 8'h00}, '{1'b0, 16'h3FFB, 8'h01}, '{1'b0, 16'h3FFC, 8'h00},
    '{1'b0, 16'h3FFD, 8'h11}, '{1'b0, 16'h7FFD, 8'h22}, '{1'b0, 16'hBFFD, 8'h33},
    '{1'b0, 16'hFFFC, 8'h00},
    '{1'b1, 16'h3FFD, 8'h11}, '{1'b1, 16'hFFFD, 8'h22}, '{1'b1, 16'h7FFD, 8'h33},
    '{1'b0, 16'hFFFB, 8'h02}, '{1'b0, 16'h3FFD, 8'h44}, '{1'b0, 16'h7FFC, 8'h03},
    '{1'b1, 16'hBFFD, 8'h44},
    '{1'b0, 16'h3FFA, 8'hAB}, '{1'b0, 16'h3FFB, 8'h0F}, '{1'b0, 16'h3FFC, 8'hFF},
    '{1'b0, 16'h3FFD, 8'h55}, '{1'b0, 16'h3FFD, 8'h66},
    '{1'b0, 16'h3FFA, 8'h00}, '{1'b0, 16'h3FFB, 8'h00}, '{1'b0, 16'h3FFC, 8'h00},
    '{1'b1, 16'h3FFD, 8'h66},
    '{1'b0, 16'hBFFA, 8'h12}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic setp(input logic [23:0] p);
    wr(16'h3FFA, p[23:16]); wr(16'h3FFB, p[15:8]); wr(16'h3FFC, p[7:0]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    port_en = 1'b1;
    wr(16'h3FFD, 8'h5A);          // lands on byte 0 if the pointer reset to 0
    wr(16'h3FFC, 8'h00);
    rd(16'h3FFD, v); check("R1 first byte at pointer 0", v, 8'h5A);

    // Table: loads, streams through mirrors, 12-bit addressing
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].a, v);
        check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), v, VEC[i].d);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end
    setp(24'h120FFF);
    rd(16'h3FFD, v); check("R6 upper bits ignored, byte FFF", v, 8'h55);

    // R7: 24-bit rollover continues at byte 0
    setp(24'hFFFFFF);
    wr(16'h3FFD, 8'h77); wr(16'h3FFD, 8'h88);
    setp(24'h000000);
    rd(16'h3FFD, v); check("R7 write after rollover at byte 0", v, 8'h88);
    setp(24'h000FFF);
    rd(16'h3FFD, v); check("R7 write before rollover at byte FFF", v, 8'h77);

    // R8: disabled port
    setp(24'h000020);
    wr(16'h3FFD, 8'hC1);           // ptr now 0x21
    port_en = 1'b0;
    wr(16'h3FFC, 8'h20);
    wr(16'h3FFD, 8'h99);
    rd(16'h3FFD, v); check("R8 disabled read leaves rdata", v, 8'h77);
    port_en = 1'b1;
    wr(16'h3FFD, 8'hC2);           // must land at 0x21
    wr(16'h3FFC, 8'h20);
    rd(16'h3FFD, v); check("R8 byte 0x20 untouched", v, 8'hC1);
    rd(16'h3FFD, v); check("R8 pointer held while disabled", v, 8'hC2);

    // R9: long strobes count once
    setp(24'h000030);
    @(negedge clk);
    bus_addr = 16'h3FFD; bus_wdata = 8'hD0; bus_wr = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr = 1'b0;
    wr(16'h3FFD, 8'hD1); wr(16'h3FFD, 8'hD2);
    wr(16'h3FFC, 8'h30);
    @(negedge clk);
    bus_addr = 16'h3FFD; bus_rd = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd = 1'b0;
    check("R9 held read returns one byte", bus_rdata, 8'hD0);
    rd(16'h3FFD, v); check("R9 one step per held strobe", v, 8'hD1);

    // R10: fixed register and other offsets ignored
    setp(24'h000040);
    wr(16'h3FFD, 8'hE0);
    wr(16'h6000, 8'h11); wr(16'h6400, 8'h22); wr(16'h7000, 8'h33);
    wr(16'h7400, 8'h44); wr(16'h7FF9, 8'h40); wr(16'h3FF9, 8'h40);
    wr(16'h3FFE, 8'h40);
    wr(16'h3FFD, 8'hE1);
    wr(16'h3FFC, 8'h40);
    rd(16'h3FFD, v); check("R10 byte 0x40", v, 8'hE0);
    rd(16'h3FFC, v); check("R10 read off port leaves rdata", v, 8'hE0);
    rd(16'h7FF9, v); check("R10 read at fixed address leaves rdata", v, 8'hE0);
    rd(16'h3FFD, v); check("R10 pointer not moved by other writes", v, 8'hE1);

    finish_run();
  end
endmodule